// File: doc/BRIEF.md
# Instruction Flow Trace Status Encoder

This block reports, once per clock, a 3-bit status word to an external program-flow tracker. The word says what kind of instruction was just fetched: sequential, a direct branch taken or not taken, an indirect or context-synchronising change of flow, an exception, or a fetch that follows a VSYNC edge. The same three wires also carry the number of instructions flushed from the instruction queue. A tracker tells the two uses apart from the code it saw one clock earlier: any type code with its top bit set (100 to 111) announces that the following clock holds a flush count.

Flush counts arrive with or without a fetch. They are summed, saturating at 7, and reported in the flush clock that follows the next type code with its top bit set. If a fetch arrives during such a flush clock, it is parked in a one-entry holding register and reported one clock later, with its order preserved. Each VSYNC edge is remembered until a fetch can report it as code 011. The fetch reported after an exception, an indirect or synchronising flow change, or a VSYNC code carries an indirect-target flag. That flag is driven out only while VSYNC is high or a show-all control input is set. Every output is registered, so a fetch in clock t is reported in clock t+1.

Top module: `vfenc_trace_status`

## Requirements
- R1: While reset is asserted and for the first idle clocks after it is released, `vf_o` is 000 and `ind_tgt_o` is 0. Reset clears the flush sum, the held fetch, the pending VSYNC edge and the indirect mark.
- R2: A clock with no fetch, no held fetch and no flush slot is reported as 000 one clock later. A plain fetch (no kind input set) is reported as 001 one clock later.
- R3: A direct branch taken is reported as 110. The next clock is always a flush slot.
- R4: An exception is reported as 100, and an indirect branch taken or a context-synchronising instruction is reported as 101. Both are followed by a flush slot and set the indirect mark on the next reported fetch.
- R5: A branch not taken is reported as 010 when the flush sum, including the count that arrives in the same clock, is zero. Otherwise it is reported as 111 and followed by a flush slot.
- R6: Flush counts from all clocks add up, saturating at 7. The sum appears in binary in the flush slot, and the slot starts a new sum from the count arriving in that clock. A flush slot is never followed directly by another flush slot.
- R7: A fetch arriving in a flush-slot clock, or while a fetch is already held, goes into the holding register and is reported in the next non-slot clock, in arrival order. The environment leaves at least one fetch-free clock between any two fetches that carry a kind input.
- R8: A change of `vsync_i` between two consecutive clocks makes the next reported fetch (other than an exception) appear as 011, and sets the indirect mark on the fetch after it. The first sample after reset is not treated as a change.
- R9: When several kind inputs are set together, or a VSYNC edge is pending, the code is chosen by priority: exception (100), then VSYNC edge (011), then indirect or synchronising (101), then direct taken (110), then not taken (010/111), then sequential (001).
- R10: `ind_tgt_o` is 1 only in the clock that reports a marked fetch, and only if `vsync_i` or `show_all_i` was high in the clock that fetch was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_vld_i | input | 1 | An instruction fetch happens this clock |
| exc_i | input | 1 | The fetch is an exception target |
| ind_br_i | input | 1 | Indirect branch taken |
| ctx_sync_i | input | 1 | Context-synchronising instruction (interrupt return, machine-state write, sync) |
| dir_tk_i | input | 1 | Direct branch taken |
| not_tk_i | input | 1 | Branch, direct or indirect, not taken |
| flush_cnt_i | input | 3 | Instructions flushed from the queue this clock |
| vsync_i | input | 1 | Trace synchronisation level |
| show_all_i | input | 1 | Show indirect targets even while VSYNC is low |
| vf_o | output | 3 | Registered status: type code or flush count |
| ind_tgt_o | output | 1 | Registered: reported fetch is an indirect target |

## Verification
The bench targets a fetch that lands in a flush slot. A design that reported it at once would break the slot, and one that dropped it would lose an instruction. It drives flush counts whose sum passes 7, which would wrap to a small number without saturation, and it places not-taken branches on both sides of pending flush counts, so a design that picks the wrong one of 010 and 111 desynchronises the tracker. VSYNC edges are made to coincide with exceptions and with combined kind inputs. A wrong priority would lose the pending edge or report it over an exception. The bench also toggles `show_all_i` with VSYNC low, which exposes an indirect-target flag that is not gated.

// File: rtl/vfenc_pkg.sv
package vfenc_pkg;

  localparam int VF_W = 3;

  typedef logic [VF_W-1:0] vf_code_t;

  localparam vf_code_t VF_IDLE          = 3'd0;
  localparam vf_code_t VF_SEQ           = 3'd1;
  localparam vf_code_t VF_NT_NEXT_TYPE  = 3'd2;
  localparam vf_code_t VF_VSYNC_EDGE    = 3'd3;
  localparam vf_code_t VF_EXC           = 3'd4;
  localparam vf_code_t VF_IND_FLOW      = 3'd5;
  localparam vf_code_t VF_DIR_TAKEN     = 3'd6;
  localparam vf_code_t VF_NT_NEXT_FLUSH = 3'd7;

  typedef struct packed {
    logic exc;
    logic ind;
    logic sync;
    logic dtk;
    logic ntk;
  } fetch_kind_t;

  function automatic logic vf_flush_follows(vf_code_t c);
    return c[VF_W-1];
  endfunction

endpackage

// File: rtl/vfenc_rst_sync.sv
module vfenc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/vfenc_vsync_track.sv
module vfenc_vsync_track (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  input  logic consume_i,
  output logic vflag_o
);

  logic vs_q;
  logic seen_q;
  logic pend_q;
  logic pend_d;
  logic edge_now;

  always_comb begin
    edge_now = seen_q & (vsync_i ^ vs_q);
    vflag_o  = pend_q | edge_now;
    pend_d   = vflag_o & ~consume_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q   <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_q   <= vsync_i;
      seen_q <= 1'b1;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/vfenc_flush_acc.sv
module vfenc_flush_acc #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] add_i,
  input  logic             drain_i,
  output logic [CNT_W-1:0] held_o,
  output logic [CNT_W-1:0] sum_o
);

  localparam int               SUM_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [SUM_W-1:0] wide;
  logic             cnt_en;

  always_comb begin
    wide   = {1'b0, cnt_q} + {1'b0, add_i};
    sum_o  = wide[CNT_W] ? CNT_MAX : wide[CNT_W-1:0];
    cnt_d  = drain_i ? add_i : sum_o;
    cnt_en = drain_i | (|add_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign held_o = cnt_q;

endmodule

// File: rtl/vfenc_hold_slot.sv
module vfenc_hold_slot
  import vfenc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  fetch_kind_t kind_i,
  input  logic        release_i,
  output logic        vld_o,
  output fetch_kind_t kind_o
);

  logic        vld_q;
  logic        vld_d;
  fetch_kind_t kind_q;

  always_comb begin
    vld_d = load_i | (vld_q & ~release_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      kind_q <= '0;
    else if (load_i) kind_q <= kind_i;
  end

  assign vld_o  = vld_q;
  assign kind_o = kind_q;

endmodule

// File: rtl/vfenc_classify.sv
module vfenc_classify
  import vfenc_pkg::*;
(
  input  logic        valid_i,
  input  fetch_kind_t kind_i,
  input  logic        vflag_i,
  input  logic        flush_nz_i,
  output vf_code_t    code_o,
  output logic        take_vflag_o,
  output logic        mark_next_o
);

  always_comb begin
    code_o = VF_IDLE;
    if (valid_i) begin
      if (kind_i.exc)                    code_o = VF_EXC;
      else if (vflag_i)                  code_o = VF_VSYNC_EDGE;
      else if (kind_i.ind | kind_i.sync) code_o = VF_IND_FLOW;
      else if (kind_i.dtk)               code_o = VF_DIR_TAKEN;
      else if (kind_i.ntk)               code_o = flush_nz_i ? VF_NT_NEXT_FLUSH : VF_NT_NEXT_TYPE;
      else                               code_o = VF_SEQ;
    end
    take_vflag_o = valid_i & (code_o == VF_VSYNC_EDGE);
    mark_next_o  = (code_o == VF_EXC) | (code_o == VF_IND_FLOW) | (code_o == VF_VSYNC_EDGE);
  end

endmodule

// File: rtl/vfenc_trace_status.sv
module vfenc_trace_status
  import vfenc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_vld_i,
  input  logic       exc_i,
  input  logic       ind_br_i,
  input  logic       ctx_sync_i,
  input  logic       dir_tk_i,
  input  logic       not_tk_i,
  input  logic [2:0] flush_cnt_i,
  input  logic       vsync_i,
  input  logic       show_all_i,
  output logic [2:0] vf_o,
  output logic       ind_tgt_o
);

  logic        rst_ns;
  fetch_kind_t cur_kind;
  fetch_kind_t hold_kind;
  fetch_kind_t sel_kind;
  logic        hold_vld;
  logic        hold_load;
  logic        hold_release;
  logic        sel_vld;
  logic        vflag;
  logic        take_vflag;
  logic        cls_mark;
  vf_code_t    cls_code;
  logic [VF_W-1:0] flush_held;
  logic [VF_W-1:0] flush_sum;

  logic        slot_due_q, slot_due_d;
  logic        in_slot_q,  in_slot_d;
  logic        attr_q,     attr_d;
  logic        attr_en;
  vf_code_t    vf_q,       vf_d;
  logic        ind_q,      ind_d;

  vfenc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_ns)
  );

  assign cur_kind = '{exc: exc_i, ind: ind_br_i, sync: ctx_sync_i,
                      dtk: dir_tk_i, ntk: not_tk_i};

  vfenc_vsync_track u_vs (
    .clk       (clk),
    .rst_n     (rst_ns),
    .vsync_i   (vsync_i),
    .consume_i (take_vflag),
    .vflag_o   (vflag)
  );

  vfenc_flush_acc #(.CNT_W(VF_W)) u_flush (
    .clk     (clk),
    .rst_n   (rst_ns),
    .add_i   (flush_cnt_i),
    .drain_i (slot_due_q),
    .held_o  (flush_held),
    .sum_o   (flush_sum)
  );

  vfenc_hold_slot u_hold (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load_i    (hold_load),
    .kind_i    (cur_kind),
    .release_i (hold_release),
    .vld_o     (hold_vld),
    .kind_o    (hold_kind)
  );

  vfenc_classify u_cls (
    .valid_i      (sel_vld),
    .kind_i       (sel_kind),
    .vflag_i      (vflag),
    .flush_nz_i   (|flush_sum),
    .code_o       (cls_code),
    .take_vflag_o (take_vflag),
    .mark_next_o  (cls_mark)
  );

  // Next-state: pick the fetch to report, or emit the flush slot.
  always_comb begin
    sel_vld      = ~slot_due_q & (hold_vld | fetch_vld_i);
    sel_kind     = hold_vld ? hold_kind : cur_kind;
    hold_load    = fetch_vld_i & (slot_due_q | hold_vld);
    hold_release = ~slot_due_q & hold_vld;
    vf_d         = slot_due_q ? flush_held : cls_code;
    ind_d        = sel_vld & attr_q & (vsync_i | show_all_i);
    attr_en      = sel_vld;
    attr_d       = cls_mark;
    slot_due_d   = sel_vld & vf_flush_follows(cls_code);
    in_slot_d    = slot_due_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      slot_due_q <= 1'b0;
      in_slot_q  <= 1'b0;
      vf_q       <= VF_IDLE;
      ind_q      <= 1'b0;
    end else begin
      slot_due_q <= slot_due_d;
      in_slot_q  <= in_slot_d;
      vf_q       <= vf_d;
      ind_q      <= ind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      attr_q <= 1'b0;
    else if (attr_en) attr_q <= attr_d;
  end

  assign vf_o      = vf_q;
  assign ind_tgt_o = ind_q;

endmodule

// File: rtl/vfenc_trace_status_chk.sv
module vfenc_trace_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_vld_i,
  input logic       exc_i,
  input logic       vsync_i,
  input logic       show_all_i,
  input logic       slot_due_q,
  input logic       in_slot_q,
  input logic       hold_vld,
  input logic [2:0] vf_o,
  input logic       ind_tgt_o
);

  // R2: nothing to report gives an idle code next clock
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_vld_i && !hold_vld && !slot_due_q) |=> (vf_o == 3'b000 && !ind_tgt_o));

  // R3, R4, R5: a type code with top bit set is followed by a flush slot
  p_type_then_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_slot_q && vf_o[2]) |=> in_slot_q);

  // R6: flush slots never come back to back
  p_slot_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot_q |=> !in_slot_q);

  // R7: holding register never asked to take a second fetch
  p_hold_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_due_q && hold_vld) |-> !fetch_vld_i);

  // R9: a directly reported exception wins over every other kind
  p_exc_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld_i && exc_i && !hold_vld && !slot_due_q) |=> (vf_o == 3'b100));

  // R10: indirect-target flag gated by visibility
  p_visible_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ind_tgt_o |-> $past(vsync_i || show_all_i));

  // R4: the flag only accompanies a reported fetch
  p_flag_on_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ind_tgt_o |-> (!in_slot_q && vf_o != 3'b000));

endmodule

bind vfenc_trace_status vfenc_trace_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_ns),
  .fetch_vld_i (fetch_vld_i),
  .exc_i       (exc_i),
  .vsync_i     (vsync_i),
  .show_all_i  (show_all_i),
  .slot_due_q  (slot_due_q),
  .in_slot_q   (in_slot_q),
  .hold_vld    (hold_vld),
  .vf_o        (vf_o),
  .ind_tgt_o   (ind_tgt_o)
);

// File: tb/vfenc_trace_status_bench.sv
module vfenc_trace_status_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RST_STAGES = 2;
  // kind vector used by the bench: [4]=exc [3]=ind [2]=sync [1]=dtk [0]=nt
  localparam logic [4:0] K_SEQ  = 5'b00000;
  localparam logic [4:0] K_NT   = 5'b00001;
  localparam logic [4:0] K_DTK  = 5'b00010;
  localparam logic [4:0] K_SYNC = 5'b00100;
  localparam logic [4:0] K_IND  = 5'b01000;
  localparam logic [4:0] K_EXC  = 5'b10000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fetch_vld_i, exc_i, ind_br_i, ctx_sync_i, dir_tk_i, not_tk_i;
  logic [2:0] flush_cnt_i;
  logic       vsync_i, show_all_i;
  logic [2:0] vf_o;
  logic       ind_tgt_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int         m_sum;
  bit         m_slot;
  bit         m_vpend;
  bit         m_mark;
  bit         m_vs_prev;
  logic [4:0] m_q[$];

  always #2.5 clk = ~clk;

  vfenc_trace_status #(.RST_STAGES(RST_STAGES)) u_vfenc_trace_status (
    .clk, .rst_n, .fetch_vld_i, .exc_i, .ind_br_i, .ctx_sync_i, .dir_tk_i,
    .not_tk_i, .flush_cnt_i, .vsync_i, .show_all_i, .vf_o, .ind_tgt_o
  );

  function automatic int ref_code(logic [4:0] k, bit vedge, bit flush_pending);
    if (k[4])            return 4;
    if (vedge)           return 3;
    if (k[3] || k[2])    return 5;
    if (k[1])            return 6;
    if (k[0])            return flush_pending ? 7 : 2;
    return 1;
  endfunction

  task automatic model_step(bit fv, logic [4:0] k, int fl, output int e_vf, output bit e_ind);
    bit vedge;
    vedge     = m_vpend || (vsync_i != m_vs_prev);
    m_vs_prev = vsync_i;
    if (fv) m_q.push_back(k);
    if (m_slot) begin
      e_vf    = m_sum;
      e_ind   = 1'b0;
      m_sum   = fl;
      m_slot  = 1'b0;
      m_vpend = vedge;
    end else begin
      m_sum = (m_sum + fl > 7) ? 7 : m_sum + fl;
      if (m_q.size() > 0) begin
        logic [4:0] a;
        a       = m_q.pop_front();
        e_vf    = ref_code(a, vedge, m_sum != 0);
        e_ind   = m_mark && (vsync_i || show_all_i);
        m_mark  = (e_vf == 3) || (e_vf == 4) || (e_vf == 5);
        m_vpend = vedge && (e_vf != 3);
        m_slot  = (e_vf >= 4);
      end else begin
        e_vf    = 0;
        e_ind   = 1'b0;
        m_vpend = vedge;
      end
    end
  endtask

  task automatic compare(string tag, int e_vf, bit e_ind);
    checks++;
    if (vf_o !== e_vf[2:0] || ind_tgt_o !== e_ind) begin
      fails++;
      $display("FAIL %s: vf_o=%0d ind_tgt_o=%0b expected vf_o=%0d ind_tgt_o=%0b (t=%0t)",
               tag, vf_o, ind_tgt_o, e_vf, e_ind, $time);
    end
  endtask

  task automatic cyc(bit fv, logic [4:0] k, int fl, string tag);
    int e_vf;
    bit e_ind;
    fetch_vld_i = fv;
    exc_i       = fv & k[4];
    ind_br_i    = fv & k[3];
    ctx_sync_i  = fv & k[2];
    dir_tk_i    = fv & k[1];
    not_tk_i    = fv & k[0];
    flush_cnt_i = fl[2:0];
    model_step(fv, fv ? k : 5'b0, fl, e_vf, e_ind);
    @(negedge clk);
    compare(tag, e_vf, e_ind);
  endtask

  task automatic do_reset(bit vs);
    rst_n = 1'b0;
    fetch_vld_i = 0; exc_i = 0; ind_br_i = 0; ctx_sync_i = 0;
    dir_tk_i = 0; not_tk_i = 0; flush_cnt_i = 0; show_all_i = 0;
    vsync_i = vs;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < RST_STAGES + 2; i++) begin
      @(negedge clk);
      compare("R1 after release", 0, 1'b0);
    end
    m_sum = 0; m_slot = 0; m_vpend = 0; m_mark = 0; m_vs_prev = vs;
    m_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: run still active after 200000 cycles, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit busy;
    @(negedge clk);
    do_reset(1'b0);

    // R2: idle and sequential
    cyc(0, K_SEQ, 0, "R2 idle");
    cyc(1, K_SEQ, 0, "R2 sequential");
    cyc(1, K_SEQ, 0, "R2 sequential");
    // R3 + R6: direct taken with flush in same clock
    cyc(1, K_DTK, 3, "R3 direct taken");
    cyc(0, K_SEQ, 0, "R3 R6 flush slot count 3");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R4: exception and indirect targets, show_all forces visibility
    show_all_i = 1'b1;
    cyc(1, K_EXC, 0, "R4 exception");
    cyc(0, K_SEQ, 0, "R4 slot");
    cyc(1, K_SEQ, 0, "R4 R10 marked target shown");
    cyc(0, K_SEQ, 0, "R2 idle");
    cyc(1, K_IND, 0, "R4 indirect taken");
    cyc(0, K_SEQ, 0, "R4 slot");
    cyc(1, K_SYNC, 0, "R4 sync after marked target");
    cyc(0, K_SEQ, 0, "R4 slot");
    cyc(1, K_SEQ, 0, "R4 marked after sync");
    cyc(0, K_SEQ, 0, "R2 idle");
    show_all_i = 1'b0;
    // R5: not taken both ways
    cyc(1, K_NT, 0, "R5 not taken no flush");
    cyc(0, K_SEQ, 0, "R5 idle");
    cyc(1, K_NT, 2, "R5 not taken with flush");
    cyc(0, K_SEQ, 0, "R5 R6 slot count 2");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R6: saturation
    cyc(0, K_SEQ, 5, "R6 flush on idle");
    cyc(1, K_SEQ, 4, "R6 flush with sequential");
    cyc(0, K_SEQ, 0, "R6 idle");
    cyc(1, K_DTK, 0, "R6 taken");
    cyc(0, K_SEQ, 1, "R6 saturated slot 7");
    cyc(1, K_NT, 0, "R5 R6 not taken after slot carry 1");
    cyc(0, K_SEQ, 0, "R6 slot 1");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R7: fetch during slot is held
    cyc(1, K_EXC, 2, "R7 exception");
    cyc(1, K_SEQ, 0, "R7 slot while fetch held");
    cyc(1, K_SEQ, 0, "R7 held fetch out");
    cyc(0, K_SEQ, 0, "R7 second held fetch out");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R8, R10: vsync edge
    vsync_i = 1'b1;
    cyc(1, K_SEQ, 0, "R8 vsync rise code");
    cyc(1, K_SEQ, 0, "R8 R10 marked shown under vsync");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R9: vsync edge together with exception, pending edge survives
    vsync_i = 1'b0;
    cyc(1, K_EXC, 0, "R9 exception over vsync");
    cyc(0, K_SEQ, 0, "R9 slot");
    cyc(1, K_SEQ, 0, "R9 R10 pending vsync, hidden");
    cyc(1, K_SEQ, 0, "R10 hidden mark");
    cyc(0, K_SEQ, 0, "R2 idle");
    // R9: combined kinds
    cyc(1, 5'b11111, 0, "R9 all kinds");
    cyc(0, K_SEQ, 0, "R9 slot");
    cyc(1, 5'b01011, 0, "R9 indirect over direct");
    cyc(0, K_SEQ, 0, "R9 slot");
    cyc(1, 5'b00011, 0, "R9 direct over not taken");
    cyc(0, K_SEQ, 0, "R9 slot");
    cyc(0, K_SEQ, 0, "R2 idle");

    // R8: vsync already high at reset exit is not an edge
    do_reset(1'b1);
    cyc(1, K_SEQ, 0, "R8 no edge after reset");
    cyc(0, K_SEQ, 0, "R2 idle");

    // mixed traffic respecting the R7 spacing rule
    busy = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      int r;
      int fl;
      logic [4:0] k;
      if ($urandom_range(0, 15) == 0) vsync_i = ~vsync_i;
      if ($urandom_range(0, 63) == 0) show_all_i = ~show_all_i;
      fl = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 0;
      r  = $urandom_range(0, 99);
      if (r < 25) begin
        busy = 1'b0;
        cyc(0, K_SEQ, fl, "R2 R6 R8 mixed idle");
      end else begin
        k = busy ? K_SEQ : (($urandom_range(0, 1) == 0) ? K_SEQ : 5'($urandom_range(1, 31)));
        if (k != K_SEQ) busy = 1'b1;
        cyc(1, k, fl, "R3 R4 R5 R7 R9 R10 mixed fetch");
      end
    end
    cyc(0, K_SEQ, 0, "R6 drain");
    cyc(0, K_SEQ, 0, "R6 drain");
    cyc(0, K_SEQ, 0, "R2 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule